// File: doc/BRIEF.md
# DRAM Power-Down and Refresh Sequencer

This block sits on the controller side of a DDR3-class memory channel. It owns the clock-enable pin and the refresh part of the command bus. It takes three kinds of request, each with a valid/ready handshake: enter power-down, leave power-down, and issue a refresh. It turns them into CKE transitions and REF or NOP/DESL commands, and each one goes out only when every timing window that guards it has closed. All timing values are synthesis parameters in clock cycles: exit-to-command delay, exit-to-next-entry delay (the DLL update window), refresh cycle time, minimum CKE level time, and the command-blocking time after entry.

Two windows run side by side. One starts at each power-down exit and limits the next entry. The other starts at each refresh and limits both the next refresh and a second CKE deassertion. A power-down may begin soon after a refresh. Once that early power-down has been left, CKE must stay high until the refresh window has closed. A refresh request has priority over a power-down entry. If a refresh request arrives during power-down, the sequencer leaves power-down by itself. An output flag tells the rest of the controller when synchronous on-die-termination timing may be used again.

Top module: `pdref_seq`

## Requirements
- R1: While `rst` is high, `cke_o` is 0, `cmd_o` is NOP (2'b00), `odt_ok` is 0 and all three ready outputs are 0, whatever the request inputs do.
- R2: After reset is released, `cke_o` rises by itself in cycle T_CKE, counting the first clock edge after release as cycle 1. No request is needed. Reset opens every window afresh, so the first REF appears no earlier than cycle max(T_CKE+T_XP, T_RFC).
- R3: A REF only appears while `cke_o` is high, and at least T_XP cycles after the most recent CKE rise. `ref_ready` is high exactly when a REF could be registered at the next edge.
- R4: Command encoding is NOP/DESL = 2'b00 and REF = 2'b01. A REF whose handshake completes in cycle n is on `cmd_o` in cycle n+1. An accepted entry or exit shows on `cke_o` in cycle n+1.
- R5: Two REF commands are at least T_RFC cycles apart.
- R6: A CKE fall comes at least T_XPDLL cycles after the most recent CKE rise, even when a REF was issued between them. With nothing else pending, the entry lands exactly T_XPDLL cycles after that rise.
- R7: CKE stays low for at least max(T_CKE, T_CPDED) cycles, and stays high for at least T_CKE cycles.
- R8: A power-down entry may follow a REF as early as the next cycle. Once that power-down is left, a second CKE fall cannot come until T_RFC cycles after the REF.
- R9: While `ref_valid` is high, `pd_enter_ready` is 0, so a refresh that is ready is issued before any power-down entry.
- R10: If `ref_valid` is high during power-down, CKE is raised as soon as its low-time windows allow, with no exit handshake. The REF then follows T_XP cycles after the rise, or later if the refresh window is still open.
- R11: `odt_ok` is 0 while CKE is low. It first goes high T_XPDLL-1 cycles after a CKE rise, which is the cycle before the earliest legal entry.
- R12: An exit request while CKE is high, and an entry request while CKE is low, are ignored: their ready stays 0 and `cke_o` keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Refresh request |
| ref_ready | output | 1 | Refresh accepted at this edge if requested |
| pd_enter_valid | input | 1 | Power-down entry request |
| pd_enter_ready | output | 1 | Entry accepted at this edge if requested |
| pd_exit_valid | input | 1 | Power-down exit request |
| pd_exit_ready | output | 1 | Exit accepted at this edge if requested |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_o | output | 2 | Command code: 2'b00 NOP/DESL, 2'b01 REF |
| odt_ok | output | 1 | Synchronous ODT timing may be used |

## Verification
The hardest state to reach is the one where a refresh window is open, an early power-down inside it has already been left, and a new entry request is waiting. Only the refresh window then holds CKE high, while the exit-to-entry window has already closed. The bench gets there by raising an entry request together with a refresh request. The refresh wins and the entry lands one cycle later. The bench then leaves power-down at once and holds the entry request. The second fall must land exactly T_RFC cycles after the REF. A separate scenario makes a refresh request force the exit while a refresh window is still open, so the REF is held back by that window and not by the exit delay.

// File: rtl/pdref_pkg.sv
package pdref_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_REF = 2'b01
    } cmd_e;

    // timer slots
    localparam int NT       = 5;
    localparam int TI_XP    = 0;
    localparam int TI_XPDLL = 1;
    localparam int TI_RFC   = 2;
    localparam int TI_CKE   = 3;
    localparam int TI_CPDED = 4;

    typedef struct packed {
        logic cke;
        logic init;     // still in the post-reset bring-up
        logic rfc_pd;   // CKE already fell inside the open refresh window
    } seq_state_t;

    typedef struct packed {
        logic ref_rdy;
        logic enter_rdy;
        logic exit_rdy;
        logic rise;
        logic fall;
        logic ref_go;
    } seq_dec_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int v);
        int w;
        w = 1;
        while ((1 << w) <= v) w++;
        return w;
    endfunction

endpackage

// File: rtl/pdref_timer.sv
module pdref_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= val;
        else if (load)         cnt_q <= val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pdref_gate.sv
module pdref_gate
    import pdref_pkg::*;
(
    input  seq_state_t  st,
    input  logic [NT-1:0] done,
    input  logic        ref_valid,
    input  logic        pd_enter_valid,
    input  logic        pd_exit_valid,
    output seq_dec_t    dec
);
    logic exit_ok;
    logic rfc_block;

    always_comb begin
        exit_ok   = !st.cke && done[TI_CKE] && done[TI_CPDED];
        rfc_block = st.rfc_pd && !done[TI_RFC];

        dec.ref_rdy   = st.cke && done[TI_XP] && done[TI_RFC];
        dec.enter_rdy = st.cke && !ref_valid && done[TI_XP] && done[TI_XPDLL]
                        && done[TI_CKE] && !rfc_block;
        dec.exit_rdy  = exit_ok && !st.init;
        dec.rise      = exit_ok && (st.init || pd_exit_valid || ref_valid);
        dec.fall      = dec.enter_rdy && pd_enter_valid;
        dec.ref_go    = dec.ref_rdy && ref_valid;
    end
endmodule

// File: rtl/pdref_seq.sv
module pdref_seq
    import pdref_pkg::*;
#(
    parameter int T_XP    = 4,
    parameter int T_XPDLL = 24,
    parameter int T_RFC   = 88,
    parameter int T_CKE   = 4,
    parameter int T_CPDED = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_valid,
    output logic       ref_ready,
    input  logic       pd_enter_valid,
    output logic       pd_enter_ready,
    input  logic       pd_exit_valid,
    output logic       pd_exit_ready,
    output logic       cke_o,
    output logic [1:0] cmd_o,
    output logic       odt_ok
);
    localparam int TMAX = max2(max2(T_XP, T_XPDLL), max2(max2(T_RFC, T_CKE), T_CPDED));
    localparam int CW   = cnt_width(TMAX - 1);
    localparam logic [CW-1:0] LV [NT] = '{
        CW'(T_XP - 1), CW'(T_XPDLL - 1), CW'(T_RFC - 1), CW'(T_CKE - 1), CW'(T_CPDED - 1)
    };

    seq_state_t    st_q;
    cmd_e          cmd_q;
    seq_dec_t      dec;
    logic [NT-1:0] done;
    logic [NT-1:0] ld;

    pdref_gate u_gate (
        .st             (st_q),
        .done           (done),
        .ref_valid      (ref_valid),
        .pd_enter_valid (pd_enter_valid),
        .pd_exit_valid  (pd_exit_valid),
        .dec            (dec)
    );

    always_comb begin
        ld           = '0;
        ld[TI_XP]    = dec.rise;
        ld[TI_XPDLL] = dec.rise;
        ld[TI_RFC]   = dec.ref_go;
        ld[TI_CKE]   = dec.rise | dec.fall;
        ld[TI_CPDED] = dec.fall;
    end

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        pdref_timer #(.W(CW)) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .load (ld[i]),
            .val  (LV[i]),
            .done (done[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '{cke: 1'b0, init: 1'b1, rfc_pd: 1'b0};
            cmd_q <= CMD_NOP;
        end else begin
            if (dec.rise) begin
                st_q.cke  <= 1'b1;
                st_q.init <= 1'b0;
            end else if (dec.fall) begin
                st_q.cke  <= 1'b0;
            end
            if (dec.fall && !done[TI_RFC]) st_q.rfc_pd <= 1'b1;
            else if (done[TI_RFC])         st_q.rfc_pd <= 1'b0;
            cmd_q <= dec.ref_go ? CMD_REF : CMD_NOP;
        end
    end

    assign ref_ready      = dec.ref_rdy;
    assign pd_enter_ready = dec.enter_rdy;
    assign pd_exit_ready  = dec.exit_rdy;
    assign cke_o          = st_q.cke;
    assign cmd_o          = cmd_q;
    assign odt_ok         = st_q.cke && done[TI_XPDLL];
endmodule

// File: rtl/pdref_seq_chk.sv
module pdref_seq_chk #(
    parameter int T_XP    = 4,
    parameter int T_XPDLL = 24,
    parameter int T_RFC   = 88,
    parameter int T_CKE   = 4,
    parameter int T_CPDED = 1
) (
    input logic       clk,
    input logic       rst,
    input logic       ref_valid,
    input logic       ref_ready,
    input logic       pd_enter_ready,
    input logic       pd_exit_ready,
    input logic       cke_o,
    input logic [1:0] cmd_o,
    input logic       odt_ok
);
    localparam logic [15:0] MIN_XP = 16'(T_XP);
    localparam logic [15:0] MIN_HI = 16'((T_XPDLL > T_CKE) ? T_XPDLL : T_CKE);
    localparam logic [15:0] MIN_LO = 16'((T_CPDED > T_CKE) ? T_CPDED : T_CKE);
    localparam logic [15:0] MIN_RF = 16'(T_RFC);

    logic        cke_prev;
    logic [15:0] lo_len, hi_len, ref_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_prev <= 1'b0;
            lo_len   <= '0;
            hi_len   <= '0;
            ref_gap  <= '1;
        end else begin
            cke_prev <= cke_o;
            lo_len   <= cke_o ? '0 : ((lo_len == '1) ? lo_len : lo_len + 1'b1);
            hi_len   <= !cke_o ? '0 : ((hi_len == '1) ? hi_len : hi_len + 1'b1);
            ref_gap  <= (cmd_o == 2'b01) ? 16'd1 : ((ref_gap == '1) ? ref_gap : ref_gap + 1'b1);
        end
    end

    // R3
    ref_after_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 2'b01) |-> (cke_o && hi_len >= MIN_XP));

    // R5
    ref_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 2'b01) |-> (ref_gap >= MIN_RF));

    // R6
    entry_after_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (cke_prev && !cke_o) |-> (hi_len >= MIN_HI));

    // R7
    low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke_prev && cke_o) |-> (lo_len >= MIN_LO));

    // R4
    ref_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && ref_ready) |=> (cmd_o == 2'b01));

    // R9
    ref_priority_chk: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> !pd_enter_ready);

    // R11
    odt_flag_chk: assert property (@(posedge clk) disable iff (rst)
        odt_ok |-> cke_o);

    // R12
    exit_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        cke_o |-> !pd_exit_ready);

    // R12
    enter_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        !cke_o |-> !pd_enter_ready);
endmodule

bind pdref_seq pdref_seq_chk #(
    .T_XP(T_XP), .T_XPDLL(T_XPDLL), .T_RFC(T_RFC), .T_CKE(T_CKE), .T_CPDED(T_CPDED)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ref_valid      (ref_valid),
    .ref_ready      (ref_ready),
    .pd_enter_ready (pd_enter_ready),
    .pd_exit_ready  (pd_exit_ready),
    .cke_o          (cke_o),
    .cmd_o          (cmd_o),
    .odt_ok         (odt_ok)
);

// File: tb/tb_pdref_seq.sv
module tb_pdref_seq;
    localparam int P_XP    = 3;
    localparam int P_XPDLL = 10;
    localparam int P_RFC   = 20;
    localparam int P_CKE   = 3;
    localparam int P_CPDED = 2;
    localparam int MAXLO   = (P_CKE > P_CPDED) ? P_CKE : P_CPDED;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_valid = 1'b0, pd_enter_valid = 1'b0, pd_exit_valid = 1'b0;
    logic ref_ready, pd_enter_ready, pd_exit_ready, cke_o, odt_ok;
    logic [1:0] cmd_o;

    pdref_seq #(.T_XP(P_XP), .T_XPDLL(P_XPDLL), .T_RFC(P_RFC), .T_CKE(P_CKE), .T_CPDED(P_CPDED)) dut (
        .clk(clk), .rst(rst),
        .ref_valid(ref_valid), .ref_ready(ref_ready),
        .pd_enter_valid(pd_enter_valid), .pd_enter_ready(pd_enter_ready),
        .pd_exit_valid(pd_exit_valid), .pd_exit_ready(pd_exit_ready),
        .cke_o(cke_o), .cmd_o(cmd_o), .odt_ok(odt_ok)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    // running rule monitor, computed from the requirements
    logic prev_cke = 1'b0;
    int last_rise = 0, last_fall = 0, last_ref = -1000, win_falls = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (cke_o && !prev_cke) begin
                chk(cyc - last_fall >= MAXLO, "R7", "low time", cyc - last_fall, MAXLO);
                last_rise = cyc;
            end
            if (!cke_o && prev_cke) begin
                chk(cyc - last_rise >= P_XPDLL, "R6", "high time before entry", cyc - last_rise, P_XPDLL);
                if (cyc - last_ref < P_RFC) begin
                    chk(win_falls == 0, "R8", "falls inside refresh window", win_falls + 1, 1);
                    win_falls++;
                end
                last_fall = cyc;
            end
            if (cmd_o == 2'b01) begin
                chk(cke_o == 1'b1, "R3", "cke during REF", int'(cke_o), 1);
                chk(cyc - last_rise >= P_XP, "R3", "REF after rise", cyc - last_rise, P_XP);
                chk(cyc - last_ref >= P_RFC, "R5", "REF spacing", cyc - last_ref, P_RFC);
                last_ref  = cyc;
                win_falls = 0;
            end
            prev_cke = cke_o;
        end
    end

    task automatic wait_cke(input logic lvl, output int c);
        c = -1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (cke_o == lvl) begin c = cyc; break; end
        end
    endtask

    task automatic wait_ref(output int c);
        ref_valid = 1'b1;
        c = -1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (cmd_o == 2'b01) begin c = cyc; break; end
        end
        ref_valid = 1'b0;
    endtask

    task automatic t_reset();
        ref_valid = 1'b1; pd_exit_valid = 1'b1; pd_enter_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R1", "cke in reset", int'(cke_o), 0);
        chk_eq("R1", "cmd in reset", int'(cmd_o), 0);
        chk_eq("R1", "readies in reset", int'({ref_ready, pd_enter_ready, pd_exit_ready}), 0);
        chk_eq("R1", "odt in reset", int'(odt_ok), 0);
        ref_valid = 1'b0; pd_exit_valid = 1'b0; pd_enter_valid = 1'b0;
        rst = 1'b0;
    endtask

    task automatic t_init();
        int rise_c = -1, odt_c = -1, ref_c = -1;
        ref_valid = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (cke_o && rise_c < 0) rise_c = cyc;
            if (odt_ok && odt_c < 0) odt_c = cyc;
            if (odt_ok && !cke_o) chk(0, "R11", "odt while cke low", 1, 0);
            if (cmd_o == 2'b01 && ref_c < 0) begin ref_c = cyc; ref_valid = 1'b0; end
        end
        ref_valid = 1'b0;
        chk_eq("R2", "bring-up rise cycle", rise_c, P_CKE);
        chk_eq("R11", "first odt cycle", odt_c, P_CKE + P_XPDLL - 1);
        chk_eq("R2", "first REF cycle", ref_c,
               (P_CKE + P_XP > P_RFC) ? P_CKE + P_XP : P_RFC);
    endtask

    task automatic t_priority_early_pd();
        int q, f, r, f2;
        repeat (25) @(negedge clk);
        ref_valid = 1'b1; pd_enter_valid = 1'b1;
        #1;
        chk_eq("R9", "enter ready with ref pending", int'(pd_enter_ready), 0);
        chk_eq("R3", "ref ready when windows closed", int'(ref_ready), 1);
        @(negedge clk);
        chk_eq("R4", "REF one cycle after grant", int'(cmd_o), 1);
        chk_eq("R9", "cke stays high on REF", int'(cke_o), 1);
        q = cyc;
        ref_valid = 1'b0;
        @(negedge clk);
        f = cyc;
        chk_eq("R8", "early entry right after REF", int'(cke_o), 0);
        chk_eq("R4", "REF lasts one cycle", int'(cmd_o), 0);
        pd_enter_valid = 1'b0; pd_exit_valid = 1'b1;
        wait_cke(1'b1, r);
        pd_exit_valid = 1'b0;
        chk_eq("R7", "exit after minimum low time", r, f + MAXLO);
        pd_enter_valid = 1'b1;
        wait_cke(1'b0, f2);
        pd_enter_valid = 1'b0;
        chk_eq("R8", "second fall held to refresh window", f2, q + P_RFC);
    endtask

    task automatic t_xpdll_auto_exit();
        int r, c, f, r2, c2, f3, t, r3, c3;
        repeat (5) @(negedge clk);
        pd_exit_valid = 1'b1;
        #1;
        chk_eq("R7", "exit ready after low time", int'(pd_exit_ready), 1);
        @(negedge clk);
        r = cyc;
        chk_eq("R4", "cke up one cycle after exit grant", int'(cke_o), 1);
        pd_exit_valid = 1'b0;
        pd_enter_valid = 1'b1;
        wait_ref(c);
        chk_eq("R3", "REF at tXP after exit", c, r + P_XP);
        wait_cke(1'b0, f);
        pd_enter_valid = 1'b0;
        chk_eq("R6", "entry at tXPDLL despite REF between", f, r + P_XPDLL);
        // refresh request during power-down, refresh window still open
        ref_valid = 1'b1;
        wait_cke(1'b1, r2);
        chk_eq("R10", "auto exit on refresh request", r2, f + MAXLO);
        wait_ref(c2);
        chk_eq("R5", "REF held by open refresh window", c2, c + P_RFC);
        pd_enter_valid = 1'b1;
        wait_cke(1'b0, f3);
        pd_enter_valid = 1'b0;
        chk_eq("R8", "first entry right after new REF", f3, c2 + 1);
        repeat (30) @(negedge clk);
        ref_valid = 1'b1;
        t = cyc;
        wait_cke(1'b1, r3);
        chk_eq("R10", "auto exit next cycle", r3, t + 1);
        wait_ref(c3);
        chk_eq("R10", "REF tXP after auto exit", c3, r3 + P_XP);
    endtask

    task automatic t_ignore();
        int f;
        pd_exit_valid = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk_eq("R12", "exit ready while high", int'(pd_exit_ready), 0);
            chk_eq("R12", "cke kept high", int'(cke_o), 1);
        end
        pd_exit_valid = 1'b0;
        pd_enter_valid = 1'b1;
        wait_cke(1'b0, f);
        chk(f > 0, "R6", "entry eventually accepted", f, 1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk_eq("R12", "enter ready while low", int'(pd_enter_ready), 0);
            chk_eq("R12", "cke kept low", int'(cke_o), 0);
            chk_eq("R11", "odt low in power-down", int'(odt_ok), 0);
        end
        pd_enter_valid = 1'b0;
    endtask

    initial begin
        t_reset();
        t_init();
        t_priority_early_pd();
        t_xpdll_auto_exit();
        t_ignore();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule